// File: doc/BRIEF.md
# Watchdog and Supply Reset Supervisor

This block produces the system reset for a small serial-memory companion chip. Two conditions pull reset: a supply-low flag, already synchronised to the block clock by an external comparator stage, and a bus watchdog. The watchdog counts clock cycles and is restarted only by a falling edge of the chip-select line. A chip select stuck at either level therefore ends in a reset. A two-bit period field taken from the status register picks one of three timeouts or turns the watchdog off. A write strobe for that field restarts the count.

Reset is active while the power-on input is low and for a fixed interval after it rises. It is also active at once, with no clock edge, while the supply is low, and it stays active for a hold-off interval once the supply is good again. A watchdog timeout gives a reset pulse of that same hold-off length. The count then starts again from zero. Every time constant is a parameter in clock cycles, so a bench can shrink them. The pin output models an open-drain driver: an output-enable is high only while reset is active, and the data value is the active level set by a polarity parameter.

There is no data stream through this block, so all pins are plain control and status with no valid/ready handshake.

Top module: `wdt_supply_supervisor`

## Requirements
- R1: While `rst_n` is low, `sys_rst` is 1. After `rst_n` rises, `sys_rst` stays 1 and falls at the PWRUP_CYC-th rising clock edge.
- R2: Whenever `low_supply` is 1, `sys_rst` is 1 in the same cycle, without waiting for a clock edge.
- R3: Once `low_supply` returns to 0, `sys_rst` stays 1 for HOLD_CYC clock edges after the first edge that samples it at 0. Any return of `low_supply` to 1 inside that window restarts the full window.
- R4: With `period_sel` = 2'b00, 2'b01 or 2'b10, the watchdog times out after T_LONG_CYC, T_MID_CYC or T_SHORT_CYC cycles of run time with no restart. The timeout sets `sys_rst`.
- R5: With `period_sel` = 2'b11, the watchdog never times out, however long chip select stays still.
- R6: Only a 1-to-0 transition of `cs_n` restarts the watchdog. The restart takes effect SYNC_STAGES clock edges after the edge that first samples the new level. A rising edge, a steady high and a steady low do not restart it.
- R7: A watchdog timeout holds `sys_rst` at 1 for HOLD_CYC cycles. After that the watchdog counts again from zero.
- R8: A cycle with `period_wr` = 1 restarts the watchdog count from zero at that clock edge.
- R9: `rst_pin_oe` is 1 exactly while `sys_rst` is 1. `rst_pin_o` is the active level: 0 when ACTIVE_HIGH = 0 and 1 when ACTIVE_HIGH = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| cs_n | input | 1 | Chip-select line, asynchronous, active low |
| low_supply | input | 1 | Supply below trip level, synchronous to clk |
| period_sel | input | 2 | Watchdog period code from the status register |
| period_wr | input | 1 | One-cycle strobe when the period field is written |
| sys_rst | output | 1 | Internal reset, active high |
| rst_pin_o | output | 1 | Pin data value, fixed at the active level |
| rst_pin_oe | output | 1 | Pin drive enable; pin floats when 0 |

## Verification
The assertions assume that `low_supply` is already synchronous to `clk` and changes only between clock edges. They also assume that `period_sel` changes only in the cycle where `period_wr` is pulsed, so a timeout is never judged against a half-written code. The bench drives every input, `cs_n` included, on the falling clock edge. It changes the period code only inside a write strobe. It runs the supply scenarios with the watchdog disabled, so the two reset causes never overlap in a way the expected counts do not cover.

// File: rtl/sup_pkg.sv
package sup_pkg;

  typedef enum logic [1:0] {
    PER_LONG  = 2'b00,
    PER_MID   = 2'b01,
    PER_SHORT = 2'b10,
    PER_OFF   = 2'b11
  } per_sel_e;

  typedef enum logic [1:0] {
    ST_PWRUP = 2'd0,
    ST_LOWV  = 2'd1,
    ST_HOLD  = 2'd2,
    ST_RUN   = 2'd3
  } sup_state_e;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/cs_fall_detect.sv
module cs_fall_detect #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  output logic fall
);
  // sh[0..SYNC_STAGES-1] synchroniser, sh[SYNC_STAGES] previous value
  logic [SYNC_STAGES:0] sh;

  genvar gi;
  generate
    for (gi = 0; gi <= SYNC_STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sh[0] <= 1'b1;
          else        sh[0] <= cs_n;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sh[gi] <= 1'b1;
          else        sh[gi] <= sh[gi-1];
        end
      end
    end
  endgenerate

  assign fall = sh[SYNC_STAGES] & ~sh[SYNC_STAGES-1];
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
  import sup_pkg::*;
#(
  parameter int unsigned T_LONG_CYC  = 1400000,
  parameter int unsigned T_MID_CYC   = 600000,
  parameter int unsigned T_SHORT_CYC = 200000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       kick,
  input  logic       restart,
  input  logic [1:0] period_sel,
  output logic       expire
);
  localparam int unsigned T_MAX = max_u(T_LONG_CYC, max_u(T_MID_CYC, T_SHORT_CYC));
  localparam int unsigned CNT_W = $clog2(T_MAX + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last_val;
  logic             enabled;
  logic             clear;

  always_comb begin
    enabled = 1'b1;
    case (per_sel_e'(period_sel))
      PER_LONG:  last_val = CNT_W'(T_LONG_CYC - 1);
      PER_MID:   last_val = CNT_W'(T_MID_CYC - 1);
      PER_SHORT: last_val = CNT_W'(T_SHORT_CYC - 1);
      default: begin
        last_val = '0;
        enabled  = 1'b0;
      end
    endcase
  end

  // a restart in the same cycle as the final count wins over the timeout
  assign expire = run & enabled & ~kick & ~restart & (cnt == last_val);
  assign clear  = ~run | ~enabled | kick | restart | expire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clear) cnt <= '0;
    else            cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/rst_sequencer.sv
module rst_sequencer
  import sup_pkg::*;
#(
  parameter int unsigned PWRUP_CYC = 200000,
  parameter int unsigned HOLD_CYC  = 200000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic low_supply,
  input  logic wd_expire,
  output logic run,
  output logic seq_active
);
  localparam int unsigned T_MAX = max_u(PWRUP_CYC, HOLD_CYC);
  localparam int unsigned CW    = $clog2(T_MAX + 1);

  sup_state_e    state;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_PWRUP;
      cnt   <= '0;
    end else if (low_supply) begin
      state <= ST_LOWV;
      cnt   <= '0;
    end else begin
      case (state)
        ST_PWRUP: begin
          if (cnt == CW'(PWRUP_CYC - 1)) begin
            state <= ST_RUN;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_LOWV: begin
          state <= ST_HOLD;
          cnt   <= '0;
        end
        ST_HOLD: begin
          if (cnt == CW'(HOLD_CYC - 1)) begin
            state <= ST_RUN;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          if (wd_expire) begin
            state <= ST_HOLD;
            cnt   <= '0;
          end
        end
      endcase
    end
  end

  assign run        = (state == ST_RUN);
  assign seq_active = (state != ST_RUN);
endmodule

// File: rtl/rst_pin_drv.sv
module rst_pin_drv #(
  parameter bit ACTIVE_HIGH = 1'b0
) (
  input  logic active,
  output logic pin_o,
  output logic pin_oe
);
  generate
    if (ACTIVE_HIGH) begin : g_hi
      assign pin_o = 1'b1;
    end else begin : g_lo
      assign pin_o = 1'b0;
    end
  endgenerate

  assign pin_oe = active;
endmodule

// File: rtl/wdt_supply_supervisor.sv
module wdt_supply_supervisor #(
  parameter int unsigned T_LONG_CYC  = 1400000,
  parameter int unsigned T_MID_CYC   = 600000,
  parameter int unsigned T_SHORT_CYC = 200000,
  parameter int unsigned HOLD_CYC    = 200000,
  parameter int unsigned PWRUP_CYC   = 200000,
  parameter int unsigned SYNC_STAGES = 2,
  parameter bit          ACTIVE_HIGH = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       low_supply,
  input  logic [1:0] period_sel,
  input  logic       period_wr,
  output logic       sys_rst,
  output logic       rst_pin_o,
  output logic       rst_pin_oe
);
  logic cs_fall;
  logic run;
  logic seq_active;
  logic wd_expire;

  cs_fall_detect #(.SYNC_STAGES(SYNC_STAGES)) u_cs (
    .clk  (clk),
    .rst_n(rst_n),
    .cs_n (cs_n),
    .fall (cs_fall)
  );

  wdt_counter #(
    .T_LONG_CYC (T_LONG_CYC),
    .T_MID_CYC  (T_MID_CYC),
    .T_SHORT_CYC(T_SHORT_CYC)
  ) u_wdt (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .kick      (cs_fall),
    .restart   (period_wr),
    .period_sel(period_sel),
    .expire    (wd_expire)
  );

  rst_sequencer #(
    .PWRUP_CYC(PWRUP_CYC),
    .HOLD_CYC (HOLD_CYC)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .low_supply(low_supply),
    .wd_expire (wd_expire),
    .run       (run),
    .seq_active(seq_active)
  );

  // supply loss bypasses the registered state so reset follows at once
  assign sys_rst = seq_active | low_supply | ~rst_n;

  rst_pin_drv #(.ACTIVE_HIGH(ACTIVE_HIGH)) u_pin (
    .active(sys_rst),
    .pin_o (rst_pin_o),
    .pin_oe(rst_pin_oe)
  );
endmodule

// File: rtl/sup_checker.sv
module sup_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       low_supply,
  input logic       sys_rst,
  input logic       wd_expire,
  input logic [1:0] period_sel,
  input logic       rst_pin_oe
);
  AST_LOW_SUPPLY_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    low_supply |-> sys_rst); // R2

  AST_RECOVERY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(low_supply) |-> sys_rst); // R3

  AST_TIMEOUT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wd_expire |=> sys_rst); // R7

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (period_sel == 2'b11) |-> !wd_expire); // R5

  AST_PIN_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst) |-> rst_pin_oe); // R9
endmodule

bind wdt_supply_supervisor sup_checker chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .low_supply(low_supply),
  .sys_rst   (sys_rst),
  .wd_expire (wd_expire),
  .period_sel(period_sel),
  .rst_pin_oe(rst_pin_oe)
);

// File: tb/wdt_supply_supervisor_tb_top.sv
`timescale 1ns/1ps
module wdt_supply_supervisor_tb_top;
  localparam int L  = 400;
  localparam int M  = 200;
  localparam int S  = 100;
  localparam int HD = 16;
  localparam int PU = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic low_supply = 1'b0;
  logic [1:0] period_sel = 2'b00;
  logic period_wr = 1'b0;
  logic sys_rst, pin_o, pin_oe;
  logic hi_rst, hi_pin_o, hi_pin_oe;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  wdt_supply_supervisor #(
    .T_LONG_CYC(L), .T_MID_CYC(M), .T_SHORT_CYC(S),
    .HOLD_CYC(HD), .PWRUP_CYC(PU), .SYNC_STAGES(2), .ACTIVE_HIGH(1'b0)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .low_supply(low_supply),
    .period_sel(period_sel), .period_wr(period_wr),
    .sys_rst(sys_rst), .rst_pin_o(pin_o), .rst_pin_oe(pin_oe)
  );

  wdt_supply_supervisor #(
    .T_LONG_CYC(L), .T_MID_CYC(M), .T_SHORT_CYC(S),
    .HOLD_CYC(HD), .PWRUP_CYC(PU), .SYNC_STAGES(2), .ACTIVE_HIGH(1'b1)
  ) dut_hi (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .low_supply(low_supply),
    .period_sel(period_sel), .period_wr(period_wr),
    .sys_rst(hi_rst), .rst_pin_o(hi_pin_o), .rst_pin_oe(hi_pin_oe)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // count consecutive falling-edge samples where sys_rst == level
  task automatic count_phase(input bit level, output int n);
    n = 0;
    forever begin
      @(negedge clk);
      if (sys_rst != level) break;
      n++;
      if (n > 5000) break;
    end
  endtask

  task automatic write_period(input logic [1:0] code);
    @(negedge clk);
    period_sel = code;
    period_wr  = 1'b1;
    @(negedge clk);
    period_wr  = 1'b0;
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    check(sys_rst == 1'b1, "R1 reset held", int'(sys_rst), 1);
    check(pin_oe == 1'b1 && pin_o == 1'b0, "R9 active-low drive", int'({pin_oe, pin_o}), 2);
    check(hi_pin_oe == 1'b1 && hi_pin_o == 1'b1, "R9 active-high drive", int'({hi_pin_oe, hi_pin_o}), 3);
  endtask

  task automatic t_powerup_and_timeout();
    int n;
    rst_n = 1'b1;
    count_phase(1'b1, n);
    check(n == PU - 1, "R1 power-up length", n, PU - 1);
    check(pin_oe == 1'b0, "R9 pin floats when idle", int'(pin_oe), 0);
    count_phase(1'b0, n); // first run sample already consumed
    check(n == L - 1, "R4 long period, cs stuck high (R6)", n, L - 1);
    count_phase(1'b1, n);
    check(n == HD - 1, "R7 timeout pulse length", n, HD - 1);
    count_phase(1'b0, n);
    check(n == L - 1, "R7 count restarts after pulse", n, L - 1);
  endtask

  // write mid-run, then measure from the write edge
  task automatic t_period(input logic [1:0] code, input int lim, input string req);
    int n;
    while (sys_rst) @(negedge clk);
    repeat (30) @(negedge clk);
    period_sel = code;
    period_wr  = 1'b1;
    @(negedge clk);
    period_wr  = 1'b0;
    check(sys_rst == 1'b0, req, int'(sys_rst), 0);
    count_phase(1'b0, n);
    check(n == lim - 1, req, n, lim - 1);
  endtask

  task automatic t_cs_edges();
    int n;
    // now in a timeout pulse with the short period selected
    count_phase(1'b1, n);
    repeat (40) @(negedge clk);
    cs_n = 1'b0; // falling edge, then stuck low
    count_phase(1'b0, n);
    check(n == S + 2, "R6 fall restarts, stuck low times out", n, S + 2);
    count_phase(1'b1, n);
    repeat (40) @(negedge clk);
    cs_n = 1'b1; // rising edge must not restart
    count_phase(1'b0, n);
    check(n == S - 41, "R6 rising edge ignored", n, S - 41);
    count_phase(1'b1, n);
    n = 0;
    for (int k = 0; k < 10; k++) begin
      repeat (55) begin
        @(negedge clk);
        if (sys_rst) n++;
      end
      cs_n = 1'b0;
      repeat (5) begin
        @(negedge clk);
        if (sys_rst) n++;
      end
      cs_n = 1'b1;
    end
    check(n == 0, "R6 periodic kicks keep reset off", n, 0);
  endtask

  task automatic t_disabled();
    int n;
    write_period(2'b11);
    n = 0;
    repeat (3 * L) begin
      @(negedge clk);
      if (sys_rst) n++;
    end
    check(n == 0, "R5 disabled code never times out", n, 0);
  endtask

  task automatic t_supply();
    int n;
    @(negedge clk);
    low_supply = 1'b1;
    #1;
    check(sys_rst == 1'b1, "R2 immediate on supply loss", int'(sys_rst), 1);
    check(pin_oe == 1'b1, "R9 pin driven on supply loss", int'(pin_oe), 1);
    repeat (5) @(negedge clk);
    low_supply = 1'b0;
    count_phase(1'b1, n);
    check(n == HD, "R3 recovery hold-off", n, HD);
    // dip inside the recovery window
    repeat (10) @(negedge clk);
    low_supply = 1'b1;
    repeat (3) @(negedge clk);
    low_supply = 1'b0;
    repeat (8) @(negedge clk);
    low_supply = 1'b1;
    @(negedge clk);
    low_supply = 1'b0;
    count_phase(1'b1, n);
    check(n == HD, "R3 dip restarts recovery window", n, HD);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    t_powerup_and_timeout();
    t_period(2'b01, M, "R8 write restarts, R4 mid period");
    t_period(2'b10, S, "R8 write restarts, R4 short period");
    t_cs_edges();
    t_disabled();
    t_supply();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule